// File: doc/BRIEF.md
# Activation-Aware Sampling Delay Compensator

A producer task writes words into a sustained channel, and a consumer task samples that channel. In the zero-time specification, every producer occurrence completes at the moment it is activated. The consumer always reads the word a fixed number of writes back. In the implementation, producer occurrences take real time to complete. A consumer occurrence may also begin some time after it was activated. Without correction, the consumer would therefore sample a word that is not the one the specification intended.

This block keeps a short history of producer words. It also keeps a signed correction counter. The counter is cleared when the consumer is activated. It then counts up on every ideal producer completion, which is signalled by the producer's activation pulse, and down on every real producer completion. When the consumer actually starts, the block forms a read index from the specified delay minus the counter. It selects that history word and reports whether the raw index had to be clamped into the buffer. Because the counter can swing either way, the read pointer can move toward newer or older words.

Top module: `act_sample_comp`

## Requirements
- R1: After reset, the correction counter is 0, every history word is 0, and rdData, rdValid, underFlag and overFlag are 0.
- R2: A consumer activation pulse sets the counter to 0 at that edge, whatever the producer pulses are doing in the same cycle.
- R3: Without activation, an ideal-completion pulse alone raises the counter by one.
- R4: Without activation, a real-completion pulse alone lowers the counter by one.
- R5: When an ideal and a real completion fall in the same cycle without activation, the counter keeps its value.
- R6: The counter never goes above CNT_MAX (default 7) or below CNT_MIN (default -4); a step that would pass a bound leaves the counter at that bound.
- R7: A start pulse sampled at an edge makes rdValid 1 for exactly the following cycle. rdData then shows history word number SPEC_DELAY (default 5) minus the counter. Both the counter and the history are taken as they stood before that edge, including when a real completion or an activation falls in the same cycle.
- R8: Each real completion shifts the history by one place: prodData enters at position 0 and the word at position DEPTH-1 (default 7) is dropped. Position k therefore holds the word written k completions before the newest.
- R9: If the raw index is below 0, the block reads position 0 and sets underFlag. If it is above DEPTH-1, the block reads position DEPTH-1 and sets overFlag. The two flags are never set together. The flags and rdData change only on a start and hold their values between starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| consActivate | input | 1 | Consumer activation pulse |
| consStart | input | 1 | Consumer actual-start pulse; triggers a read |
| prodIdeal | input | 1 | Producer ideal-completion (activation) pulse |
| prodDone | input | 1 | Producer real-completion pulse, qualifies prodData |
| prodData | input | DATA_W | Word written by the producer on completion |
| rdData | output | DATA_W | Word selected at the last start |
| rdValid | output | 1 | One-cycle pulse after a start |
| underFlag | output | 1 | Last raw index was below zero |
| overFlag | output | 1 | Last raw index was beyond the history depth |

## Verification
The critical overlap is a consumer start that lands in the same cycle as a real producer completion. The read must use the history before the shift and the counter before the decrement. The bench forces this overlap directly, and it also arises often in its random traffic. The predicted word is taken from a reference copy of the history that is updated only after the read has been resolved. A second overlap, an activation together with an ideal completion, is checked by a later start whose index must reflect a cleared counter.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef struct packed {
    logic shiftEn;
    logic sampleEn;
    logic underHit;
    logic overHit;
  } ascStrobe_t;

  function automatic int cntWidth(input int lo, input int hi);
    int mag;
    mag = (-lo > hi) ? -lo : hi;
    return $clog2(mag + 1) + 1;
  endfunction

endpackage

// File: rtl/asc_ctrl.sv
module asc_ctrl
  import asc_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SPEC_DELAY = 5,
  parameter int CNT_MIN    = -4,
  parameter int CNT_MAX    = 7,
  localparam int CW = cntWidth(CNT_MIN, CNT_MAX),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 consActivate,
  input  logic                 consStart,
  input  logic                 prodIdeal,
  input  logic                 prodDone,
  output ascStrobe_t           strobe,
  output logic [IW-1:0]        readIdx,
  output logic signed [CW-1:0] cntQ
);

  localparam logic signed [CW-1:0] ONE    = 1;
  localparam logic signed [CW-1:0] CNTTOP = CW'(CNT_MAX);
  localparam logic signed [CW-1:0] CNTBOT = CW'(CNT_MIN);

  logic signed [CW-1:0] cntD;
  int rawIdx;
  int clampIdx;
  logic underHit;
  logic overHit;

  // correction counter: activation wins, coincident up/down holds
  always_comb begin
    cntD = cntQ;
    if (consActivate) begin
      cntD = '0;
    end else if (prodIdeal && !prodDone) begin
      if (cntQ < CNTTOP) cntD = cntQ + ONE;
    end else if (prodDone && !prodIdeal) begin
      if (cntQ > CNTBOT) cntD = cntQ - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntD;
  end

  // read index from the counter as it stands before this edge
  always_comb begin
    rawIdx   = SPEC_DELAY - int'(cntQ);
    underHit = 1'b0;
    overHit  = 1'b0;
    clampIdx = rawIdx;
    if (rawIdx < 0) begin
      underHit = 1'b1;
      clampIdx = 0;
    end else if (rawIdx > DEPTH - 1) begin
      overHit  = 1'b1;
      clampIdx = DEPTH - 1;
    end
  end

  assign readIdx         = IW'(clampIdx);
  assign strobe.shiftEn  = prodDone;
  assign strobe.sampleEn = consStart;
  assign strobe.underHit = underHit;
  assign strobe.overHit  = overHit;

endmodule

// File: rtl/asc_dp.sv
module asc_dp
  import asc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ascStrobe_t        strobe,
  input  logic [IW-1:0]     readIdx,
  input  logic [DATA_W-1:0] prodData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              underFlag,
  output logic              overFlag
);

  logic [DATA_W-1:0] hist     [DEPTH];
  logic [DATA_W-1:0] histNext [DEPTH];

  // next-state of each history stage
  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    if (g == 0) begin : gHead
      assign histNext[g] = prodData;
    end else begin : gTail
      assign histNext[g] = hist[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (strobe.shiftEn) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= histNext[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
    end else begin
      rdValid <= strobe.sampleEn;
      if (strobe.sampleEn) begin
        rdData    <= hist[readIdx];
        underFlag <= strobe.underHit;
        overFlag  <= strobe.overHit;
      end
    end
  end

endmodule

// File: rtl/act_sample_comp.sv
module act_sample_comp
  import asc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int SPEC_DELAY = 5,
  parameter int CNT_MIN    = -4,
  parameter int CNT_MAX    = 7,
  localparam int CW = cntWidth(CNT_MIN, CNT_MAX),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              consActivate,
  input  logic              consStart,
  input  logic              prodIdeal,
  input  logic              prodDone,
  input  logic [DATA_W-1:0] prodData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              underFlag,
  output logic              overFlag
);

  ascStrobe_t           strobe;
  logic [IW-1:0]        readIdx;
  logic signed [CW-1:0] cntQ;

  asc_ctrl #(
    .DEPTH(DEPTH), .SPEC_DELAY(SPEC_DELAY),
    .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .consActivate(consActivate), .consStart(consStart),
    .prodIdeal(prodIdeal), .prodDone(prodDone),
    .strobe(strobe), .readIdx(readIdx), .cntQ(cntQ)
  );

  asc_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .readIdx(readIdx),
    .prodData(prodData), .rdData(rdData), .rdValid(rdValid),
    .underFlag(underFlag), .overFlag(overFlag)
  );

endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter int DATA_W  = 16,
  parameter int CNT_MIN = -4,
  parameter int CNT_MAX = 7,
  parameter int CW      = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 consActivate,
  input logic                 consStart,
  input logic                 prodIdeal,
  input logic                 prodDone,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdValid,
  input logic                 underFlag,
  input logic                 overFlag,
  input logic signed [CW-1:0] cnt
);

  a_r2_activate_clears: assert property (@(posedge clk) disable iff (!rstN)
    consActivate |=> cnt == '0);

  a_r3_ideal_up: assert property (@(posedge clk) disable iff (!rstN)
    (!consActivate && prodIdeal && !prodDone && int'(cnt) < CNT_MAX)
      |=> int'(cnt) == int'($past(cnt)) + 1);

  a_r4_real_down: assert property (@(posedge clk) disable iff (!rstN)
    (!consActivate && prodDone && !prodIdeal && int'(cnt) > CNT_MIN)
      |=> int'(cnt) == int'($past(cnt)) - 1);

  a_r5_coincide_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!consActivate && prodDone && prodIdeal) |=> $stable(cnt));

  a_r6_in_bounds: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) >= CNT_MIN && int'(cnt) <= CNT_MAX);

  a_r7_valid_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    consStart |=> rdValid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !consStart |=> !rdValid);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(underFlag && overFlag));

  a_r9_hold_between_starts: assert property (@(posedge clk) disable iff (!rstN)
    !consStart |=> ($stable(rdData) && $stable(underFlag) && $stable(overFlag)));

endmodule

bind act_sample_comp asc_checker #(
  .DATA_W(DATA_W), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX), .CW(CW)
) u_chk (
  .clk(clk), .rstN(rstN), .consActivate(consActivate), .consStart(consStart),
  .prodIdeal(prodIdeal), .prodDone(prodDone), .rdData(rdData),
  .rdValid(rdValid), .underFlag(underFlag), .overFlag(overFlag), .cnt(cntQ)
);

// File: tb/act_sample_comp_tb.sv
`timescale 1ns/1ps
module act_sample_comp_tb;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int SPEC   = 5;
  localparam int CMIN   = -4;
  localparam int CMAX   = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic consActivate = 1'b0, consStart = 1'b0, prodIdeal = 1'b0, prodDone = 1'b0;
  logic [DATA_W-1:0] prodData = '0;
  logic [DATA_W-1:0] rdData;
  logic rdValid, underFlag, overFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mCnt;
  logic [DATA_W-1:0] mHist [DEPTH];
  logic [DATA_W-1:0] mData;
  bit mUnder, mOver;

  always #4 clk = ~clk;

  act_sample_comp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SPEC_DELAY(SPEC),
                    .CNT_MIN(CMIN), .CNT_MAX(CMAX)) u_dut (
    .clk(clk), .rstN(rstN), .consActivate(consActivate), .consStart(consStart),
    .prodIdeal(prodIdeal), .prodDone(prodDone), .prodData(prodData),
    .rdData(rdData), .rdValid(rdValid), .underFlag(underFlag), .overFlag(overFlag)
  );

  function automatic int rawIndex(input int c);
    return SPEC - c;
  endfunction

  function automatic int clampIndex(input int r);
    if (r < 0) return 0;
    if (r > DEPTH - 1) return DEPTH - 1;
    return r;
  endfunction

  function automatic int nextCnt(input int c, input bit act, input bit idl, input bit dn);
    if (act) return 0;
    if (idl && !dn) return (c < CMAX) ? c + 1 : c;
    if (dn && !idl) return (c > CMIN) ? c - 1 : c;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at the negedge, predict, compare after the edge
  task automatic cyc(input bit act, input bit st, input bit idl, input bit dn,
                     input logic [DATA_W-1:0] d, input string req);
    int r;
    consActivate = act; consStart = st; prodIdeal = idl; prodDone = dn; prodData = d;
    @(posedge clk);
    #1;
    if (st) begin
      r = rawIndex(mCnt);
      mUnder = (r < 0);
      mOver  = (r > DEPTH - 1);
      mData  = mHist[clampIndex(r)];
    end
    mCnt = nextCnt(mCnt, act, idl, dn);
    if (dn) begin
      for (int i = DEPTH - 1; i > 0; i--) mHist[i] = mHist[i-1];
      mHist[0] = d;
    end
    chk(rdValid == st, {req, " rdValid"}, rdValid, st);
    chk(rdData == mData, {req, " rdData"}, rdData, mData);
    chk(underFlag == mUnder, {req, " underFlag"}, underFlag, mUnder);
    chk(overFlag == mOver, {req, " overFlag"}, overFlag, mOver);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mCnt = 0; mData = '0; mUnder = 0; mOver = 0;
    for (int i = 0; i < DEPTH; i++) mHist[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, then a read from the cleared history
    chk(rdValid == 0 && rdData == 0 && !underFlag && !overFlag, "R1 reset outputs",
        {rdValid, underFlag, overFlag, rdData}, 0);
    cyc(0, 1, 0, 0, 0, "R1 cleared history read");
    // R8 fill the history with known words
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1, 16'(100 + i), "R8 fill");
    cyc(0, 1, 0, 0, 0, "R8 ordered history");
    // R2 activation beats a coincident ideal pulse
    cyc(0, 0, 1, 0, 0, "R2 prep");
    cyc(1, 0, 1, 0, 0, "R2 act with ideal");
    cyc(0, 1, 0, 0, 0, "R2 cleared index");
    // R3 three ideal completions
    cyc(1, 0, 0, 0, 0, "R3 act");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R3 ideal");
    cyc(0, 1, 0, 0, 0, "R3 index after ups");
    // R5 coincident ideal and real completion
    cyc(0, 0, 1, 1, 16'h0AAA, "R5 both");
    cyc(0, 0, 1, 1, 16'h0BBB, "R5 both");
    cyc(0, 1, 0, 0, 0, "R5 held counter");
    // R6 upper saturation, R9 under flag
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 0, "R6 ideal burst");
    cyc(0, 1, 0, 0, 0, "R9 under clamp");
    cyc(0, 0, 0, 0, 0, "R9 hold");
    // R4 real completions, R6 lower saturation, R9 over flag
    cyc(1, 0, 0, 0, 0, "R4 act");
    cyc(0, 0, 0, 1, 16'h1111, "R4 done");
    cyc(0, 1, 0, 0, 0, "R4 index after down");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 16'(16'h2000 + i), "R6 done burst");
    cyc(0, 1, 0, 0, 0, "R9 over clamp");
    // R7 start together with a real completion and with an activation
    cyc(1, 0, 0, 0, 0, "R7 act");
    cyc(0, 1, 0, 1, 16'h3333, "R7 start with done");
    cyc(0, 0, 1, 0, 0, "R7 ideal");
    cyc(1, 1, 0, 0, 0, "R7 start with act");
    cyc(0, 1, 0, 0, 0, "R7 after act");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 16) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
          ($urandom % 3) == 0, 16'($urandom), "R7 random");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule